// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block controls one port of up to sixteen general-purpose pins. Software reaches it through a small synchronous register port with four byte strobes. For every pin it sets a direction mode, a driver type, a drive-strength code and a pull selection. From these settings and the pin's data source, the block computes the pad controls: drive value, output enable, pull-up enable, pull-down enable and analog switch. A pin can take its output data from the port's own data register or from an on-chip peripheral. The pin level that comes back from the pad is synchronized and can be read by software. The same level is also passed on to the peripherals.

Output data can be changed in two ways. Software can write the data register directly. It can also write a set/clear register, which changes only the pins named in the written word. This second path updates the output state in a single bus access, with no read-modify-write sequence, so an interrupt cannot arrive between reading and writing back the output state.

Top module: `gpio_port`

## Requirements
- R1: Every writable register takes per-byte strobes. Strobe bit k enables bus byte k, which is bits 8k+7..8k of the word. A byte whose strobe is low keeps its previous value.
- R2: The register offsets on the 3-bit bus address are: 0 mode (2 bits per pin, pin i at bits 2i+1..2i), 1 driver type (bit i), 2 drive strength (2 bits per pin), 3 pull (2 bits per pin), 4 input data (read-only), 5 output data, 6 set/clear. A read returns its data on bus_rdata one cycle later, with bus_rvalid high.
- R3: The mode code is 00 input, 01 output, 10 peripheral and 11 analog. The output enable of a pin is high only in modes 01 and 10, and pad_analog is high only in mode 11.
- R4: In mode 01 the pin drives the value of its output data bit. In mode 10 it drives perif_drive instead.
- R5: A driver type bit of 0 means push-pull: pad_out equals the data and pad_oe is 1. A driver type bit of 1 means open-drain: pad_out is 0 and pad_oe is the inverse of the data, so the pad is only ever pulled low.
- R6: The pull code is 00 none, 01 pull-up and 10 pull-down. Code 11 enables neither pull, and a pin in analog mode enables neither pull.
- R7: In a write to the set/clear register, bits 15..0 set and bits 31..16 clear the matching output data bits, subject to the byte strobes. When both are written for the same pin, set wins. Zero bits leave their pins unchanged, and a read of this register returns 0.
- R8: A pad level reaches the input data register and perif_sense after two clock edges. A pin in analog mode reads as 0.
- R9: Each pin's drive-strength code is sent unchanged to pad_speed and has no other effect.
- R10: After reset every register reads 0. All pins are then inputs: push-pull, lowest drive strength, no pull, and no output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | 16 | Level seen at each pad |
| pad_out | output | 16 | Drive value per pad |
| pad_oe | output | 16 | Output enable per pad |
| pad_pu | output | 16 | Pull-up enable per pad |
| pad_pd | output | 16 | Pull-down enable per pad |
| pad_speed | output | 32 | Drive-strength code, 2 bits per pad |
| pad_analog | output | 16 | Analog switch enable per pad |
| perif_drive | input | 16 | Peripheral data for pins in peripheral mode |
| perif_sense | output | 16 | Synchronized pad level to peripherals |

## Verification
Two cases are hard to reach. The first is a set/clear write in which set and clear bits collide on one pin while other lanes are masked off. The second is the open-drain enable when the data source is a peripheral rather than the data register. To reach the first, the stimulus preloads a known output pattern, writes words that name the same pin in both halves, and then writes a word that has only the clear strobes. It reads the result back through the data register. To reach the second, the stimulus switches all pins to peripheral mode, makes half of them open-drain, and checks the pad enables against the inverse of the peripheral data.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int BUS_W  = 32;
   localparam int LANE_W = 8;
   localparam int LANES  = BUS_W / LANE_W;
   localparam int HALF_W = BUS_W / 2;

   typedef enum logic [1:0] {
      PM_INPUT  = 2'b00,
      PM_OUTPUT = 2'b01,
      PM_PERIPH = 2'b10,
      PM_ANALOG = 2'b11
   } pin_mode_e;

   typedef enum logic [1:0] {
      PULL_NONE = 2'b00,
      PULL_UP   = 2'b01,
      PULL_DOWN = 2'b10,
      PULL_RSVD = 2'b11
   } pull_code_e;

   localparam logic [2:0] OFS_MODE   = 3'd0;
   localparam logic [2:0] OFS_DTYPE  = 3'd1;
   localparam logic [2:0] OFS_SPEED  = 3'd2;
   localparam logic [2:0] OFS_PULL   = 3'd3;
   localparam logic [2:0] OFS_IDATA  = 3'd4;
   localparam logic [2:0] OFS_ODATA  = 3'd5;
   localparam logic [2:0] OFS_SETCLR = 3'd6;

   function automatic logic [BUS_W-1:0] lane_mask(input logic [LANES-1:0] be);
      logic [BUS_W-1:0] m;
      for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = {LANE_W{be[i]}};
      return m;
   endfunction

   function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_v,
                                                     input logic [BUS_W-1:0] new_v,
                                                     input logic [LANES-1:0] be);
      logic [BUS_W-1:0] m;
      m = lane_mask(be);
      return (old_v & ~m) | (new_v & m);
   endfunction
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_pkg::*;
#(
   parameter int NPINS  = 16,
   parameter int ADDR_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [BUS_W-1:0]       wdata,
   input  logic [LANES-1:0]       be,
   output logic [2*NPINS-1:0]     mode_q,
   output logic [NPINS-1:0]       dtype_q,
   output logic [2*NPINS-1:0]     speed_q,
   output logic [2*NPINS-1:0]     pull_q,
   output logic [NPINS-1:0]       odata_q
);
   localparam int FIELD2_W = 2 * NPINS;

   logic [BUS_W-1:0] mode_w, dtype_w, speed_w, pull_w, odata_w;
   logic [BUS_W-1:0] strobe_m;
   logic [NPINS-1:0] set_v, clr_v;
   logic hit_mode, hit_dtype, hit_speed, hit_pull, hit_odata, hit_setclr;

   assign hit_mode   = wr_en && (addr == ADDR_W'(OFS_MODE));
   assign hit_dtype  = wr_en && (addr == ADDR_W'(OFS_DTYPE));
   assign hit_speed  = wr_en && (addr == ADDR_W'(OFS_SPEED));
   assign hit_pull   = wr_en && (addr == ADDR_W'(OFS_PULL));
   assign hit_odata  = wr_en && (addr == ADDR_W'(OFS_ODATA));
   assign hit_setclr = wr_en && (addr == ADDR_W'(OFS_SETCLR));

   assign mode_w  = lane_merge(BUS_W'(mode_q),  wdata, be);
   assign dtype_w = lane_merge(BUS_W'(dtype_q), wdata, be);
   assign speed_w = lane_merge(BUS_W'(speed_q), wdata, be);
   assign pull_w  = lane_merge(BUS_W'(pull_q),  wdata, be);
   assign odata_w = lane_merge(BUS_W'(odata_q), wdata, be);

   assign strobe_m = lane_mask(be);
   assign set_v    = wdata[NPINS-1:0] & strobe_m[NPINS-1:0];
   assign clr_v    = wdata[HALF_W +: NPINS] & strobe_m[HALF_W +: NPINS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         dtype_q <= '0;
         speed_q <= '0;
         pull_q  <= '0;
         odata_q <= '0;
      end else begin
         if (hit_mode)  mode_q  <= mode_w[FIELD2_W-1:0];
         if (hit_dtype) dtype_q <= dtype_w[NPINS-1:0];
         if (hit_speed) speed_q <= speed_w[FIELD2_W-1:0];
         if (hit_pull)  pull_q  <= pull_w[FIELD2_W-1:0];
         if (hit_odata)
            odata_q <= odata_w[NPINS-1:0];
         else if (hit_setclr)
            odata_q <= (odata_q & ~clr_v) | set_v;
      end
   end
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
   import gpio_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       open_drain,
   input  logic [1:0] pull,
   input  logic       reg_data,
   input  logic       perif_data,
   output logic       out,
   output logic       oe,
   output logic       pu,
   output logic       pd,
   output logic       analog
);
   pin_mode_e  m;
   pull_code_e p;
   logic drive, src;

   assign m = pin_mode_e'(mode);
   assign p = pull_code_e'(pull);

   always_comb begin
      drive  = (m == PM_OUTPUT) || (m == PM_PERIPH);
      src    = (m == PM_PERIPH) ? perif_data : reg_data;
      analog = (m == PM_ANALOG);
      if (open_drain) begin
         out = 1'b0;
         oe  = drive & ~src;
      end else begin
         out = drive & src;
         oe  = drive;
      end
      pu = !analog && (p == PULL_UP);
      pd = !analog && (p == PULL_DOWN);
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NPINS  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] level_in,
   input  logic [NPINS-1:0] gate_off,
   output logic [NPINS-1:0] level_out
);
   logic [NPINS-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= level_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign level_out = chain[STAGES-1] & ~gate_off;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int NPINS       = 16,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic [3:0]           bus_be,
   output logic [31:0]          bus_rdata,
   output logic                 bus_rvalid,
   input  logic [NPINS-1:0]     pad_in,
   output logic [NPINS-1:0]     pad_out,
   output logic [NPINS-1:0]     pad_oe,
   output logic [NPINS-1:0]     pad_pu,
   output logic [NPINS-1:0]     pad_pd,
   output logic [2*NPINS-1:0]   pad_speed,
   output logic [NPINS-1:0]     pad_analog,
   input  logic [NPINS-1:0]     perif_drive,
   output logic [NPINS-1:0]     perif_sense
);
   if (NPINS < 1 || NPINS > HALF_W) begin : g_bad_npins
      $error("gpio_port: NPINS must lie in 1..16");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("gpio_port: ADDR_W must be at least 3");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port: SYNC_STAGES must be at least 2");
   end

   logic [2*NPINS-1:0] mode_q, speed_q, pull_q;
   logic [NPINS-1:0]   dtype_q, odata_q, idata;
   logic [NPINS-1:0]   analog_v;
   logic               wr_en, rd_en;
   logic [31:0]        rd_mux;

   assign wr_en = bus_sel & bus_wr;
   assign rd_en = bus_sel & ~bus_wr;

   gpio_cfg_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
      .wdata(bus_wdata), .be(bus_be),
      .mode_q(mode_q), .dtype_q(dtype_q), .speed_q(speed_q),
      .pull_q(pull_q), .odata_q(odata_q)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      gpio_pin_drv u_drv (
         .mode(mode_q[2*i +: 2]), .open_drain(dtype_q[i]), .pull(pull_q[2*i +: 2]),
         .reg_data(odata_q[i]), .perif_data(perif_drive[i]),
         .out(pad_out[i]), .oe(pad_oe[i]), .pu(pad_pu[i]), .pd(pad_pd[i]),
         .analog(analog_v[i])
      );
   end

   assign pad_analog = analog_v;
   assign pad_speed  = speed_q;

   gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .level_in(pad_in), .gate_off(analog_v),
      .level_out(idata)
   );

   assign perif_sense = idata;

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         ADDR_W'(OFS_MODE):  rd_mux = 32'(mode_q);
         ADDR_W'(OFS_DTYPE): rd_mux = 32'(dtype_q);
         ADDR_W'(OFS_SPEED): rd_mux = 32'(speed_q);
         ADDR_W'(OFS_PULL):  rd_mux = 32'(pull_q);
         ADDR_W'(OFS_IDATA): rd_mux = 32'(idata);
         ADDR_W'(OFS_ODATA): rd_mux = 32'(odata_q);
         default:            rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= rd_en;
         if (rd_en) bus_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int NPINS  = 16,
   parameter int ADDR_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_wdata,
   input logic [3:0]         bus_be,
   input logic [31:0]        bus_rdata,
   input logic               bus_rvalid,
   input logic [2*NPINS-1:0] mode_q,
   input logic [NPINS-1:0]   dtype_q,
   input logic [NPINS-1:0]   odata_q,
   input logic [NPINS-1:0]   pad_out,
   input logic [NPINS-1:0]   pad_oe,
   input logic [NPINS-1:0]   pad_pu,
   input logic [NPINS-1:0]   pad_pd
);
   logic [31:0]      bm;
   logic [NPINS-1:0] setv, clrv, quiet;
   logic             sc_wr, sc_rd;

   always_comb begin
      for (int i = 0; i < 4; i++) bm[8*i +: 8] = {8{bus_be[i]}};
      for (int i = 0; i < NPINS; i++) quiet[i] = (mode_q[2*i +: 2] == 2'b00) || (mode_q[2*i +: 2] == 2'b11);
   end
   assign setv  = bus_wdata[NPINS-1:0] & bm[NPINS-1:0];
   assign clrv  = bus_wdata[16 +: NPINS] & bm[16 +: NPINS];
   assign sc_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(6));
   assign sc_rd = bus_sel && !bus_wr && (bus_addr == ADDR_W'(6));

   assert_set_applied_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sc_wr |=> ((odata_q & $past(setv)) == $past(setv)));
   assert_clear_applied_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sc_wr |=> ((odata_q & $past(clrv) & ~$past(setv)) == '0));
   assert_untouched_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sc_wr |=> (((odata_q ^ $past(odata_q)) & ~($past(setv) | $past(clrv))) == '0));
   assert_setclr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sc_rd |=> (bus_rvalid && bus_rdata == '0));
   assert_quiet_no_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & quiet) == '0));
   assert_open_drain_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & dtype_q) == '0));
   assert_pulls_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu & pad_pd) == '0));
endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
   .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
   .mode_q(mode_q), .dtype_q(dtype_q), .odata_q(odata_q),
   .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [15:0] pad_in = '0, perif_drive = '0;
   logic [15:0] pad_out, pad_oe, pad_pu, pad_pd, pad_analog, perif_sense;
   logic [31:0] pad_speed;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   gpio_port u_gpio_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
      .pad_speed(pad_speed), .pad_analog(pad_analog),
      .perif_drive(perif_drive), .perif_sense(perif_sense)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as responses appear
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) check("R2 unexpected read response", bus_rdata, 32'hx);
         else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      check("R10 pad_oe after reset", 32'(pad_oe), 32'h0);
      check("R10 pulls after reset", 32'(pad_pu | pad_pd), 32'h0);
      for (int a = 0; a < 7; a++) rd(3'(a), 32'h0, "R10 register reset value");

      // R1 byte lanes
      wr(3'd0, 32'hFFFF_FFFF, 4'b0001);
      rd(3'd0, 32'h0000_00FF, "R1 lane0 only");
      wr(3'd0, 32'h1234_5678, 4'b0100);
      rd(3'd0, 32'h0034_00FF, "R1 lane2 only, lane0 kept");
      wr(3'd0, 32'h0, 4'b1111);

      // R7 set/clear
      wr(3'd5, 32'h0000_00F0, 4'b0011);
      wr(3'd6, 32'h0011_0003, 4'b1111);
      rd(3'd5, 32'h0000_00E3, "R7 set wins, others unchanged");
      rd(3'd6, 32'h0, "R7 set/clear reads zero");
      wr(3'd6, 32'h0000_FFFF, 4'b1100);
      rd(3'd5, 32'h0000_00E3, "R7 masked set lanes ignored");
      wr(3'd6, 32'h00E0_0000, 4'b1111);
      rd(3'd5, 32'h0000_0003, "R7 clear only named pins");

      // R3/R4 output mode
      wr(3'd5, 32'h0000_A5A5, 4'b0011);
      wr(3'd0, 32'h5555_5555, 4'b1111);
      @(negedge clk);
      check("R4 pad_out from data reg", 32'(pad_out), 32'hA5A5);
      check("R3 oe in output mode", 32'(pad_oe), 32'hFFFF);

      // R5 open-drain
      wr(3'd1, 32'h0000_FFFF, 4'b0011);
      @(negedge clk);
      check("R5 open-drain never drives high", 32'(pad_out), 32'h0);
      check("R5 open-drain enable is inverse data", 32'(pad_oe), 32'h5A5A);

      // R4/R5 peripheral source
      perif_drive = 16'h0F0F;
      wr(3'd0, 32'hAAAA_AAAA, 4'b1111);
      wr(3'd1, 32'h0000_FF00, 4'b0011);
      @(negedge clk);
      check("R4 peripheral data on pads", 32'(pad_out), 32'h000F);
      check("R5 peripheral open-drain enables", 32'(pad_oe), 32'hF0FF);

      // R6 pulls
      wr(3'd0, 32'h0, 4'b1111);
      wr(3'd1, 32'h0, 4'b0011);
      wr(3'd3, 32'h0000_00E4, 4'b1111);
      @(negedge clk);
      check("R6 pull-up code 01", 32'(pad_pu), 32'h0002);
      check("R6 pull-down code 10, 11 none", 32'(pad_pd), 32'h0004);
      check("R3 oe low in input mode", 32'(pad_oe), 32'h0);
      wr(3'd0, 32'h0000_003C, 4'b0001);
      @(negedge clk);
      check("R6 analog disables pulls", 32'(pad_pu | pad_pd), 32'h0);
      check("R3 analog switch", 32'(pad_analog), 32'h0006);

      // R8 input path
      wr(3'd0, 32'h0, 4'b1111);
      pad_in = 16'h1234;
      @(negedge clk);
      check("R8 not visible after one edge", 32'(perif_sense), 32'h0);
      @(negedge clk);
      check("R8 visible after two edges", 32'(perif_sense), 32'h1234);
      rd(3'd4, 32'h0000_1234, "R8 input data register");
      wr(3'd0, 32'h0000_0300, 4'b0010);
      rd(3'd4, 32'h0000_1224, "R8 analog pin reads zero");

      // R9 speed
      wr(3'd2, 32'hDEAD_BEEF, 4'b1111);
      @(negedge clk);
      check("R9 speed exported", pad_speed, 32'hDEAD_BEEF);
      check("R9 speed has no effect on pad data", 32'(pad_out), 32'h0);
      rd(3'd2, 32'hDEAD_BEEF, "R9 speed readback");
      rd(3'd7, 32'h0, "R2 unused offset reads zero");

      repeat (4) @(negedge clk);
      check("R2 all reads answered", 32'(exp_q.size()), 32'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule